// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers sixteen interrupt sources into one request and a vector index for a processor core. Five sources sit directly at the core level: a serial-receive line that can instead serve as external request zero, a serial-transmit line that can instead serve as external request one, a timer, and two software requests. The other eleven come from motor-control peripherals: a PWM trip input, a PWM sync pulse and nine programmable I/O lines.

Every source is captured on its rising edge into a sticky pending bit. The peripheral pending bits are masked one by one and ORed into a single core-level line. That line is arbitrated with the five core sources under a fixed priority. Software reads the peripheral status to see which peripheral fired, and clears those bits by writing ones. The processor acknowledges a core-level source, which clears its pending bit. A global enable gates the request output.

Top module: `irqController`

## Requirements
- R1: While reset is held and right after it, every pending bit is clear, so `irqReq` is 0, `irqVec` is 0, `periphStatus` is 0 and `periphVec` is 0.
- R2: A 0-to-1 change on `coreReq[i]` sets core pending bit i at the next clock edge. Core bit 0 is serial receive or external request 0, bit 1 is serial transmit or external request 1, bit 2 is the timer, and bits 3 and 4 are the software requests. Core bit i maps to arbitration line i+1.
- R3: A 0-to-1 change on `periphReq[j]` sets `periphStatus[j]` at the next edge, and the bit stays set. Holding the input high does not set the bit again after it is cleared. Bit 0 is PWM trip, bit 1 is PWM sync, and bits 2 to 10 are I/O lines 0 to 8.
- R4: When `periphClrWr` is 1, every status bit whose `periphClrData` bit is 1 clears at the next edge. If a new rising edge arrives on that bit in the same cycle, the bit stays set.
- R5: A mask bit of 0 stops its pending source from taking part in arbitration. The pending bit itself is kept, and `periphStatus` still shows peripheral bits whatever their masks.
- R6: Arbitration line 0 is active when at least one peripheral bit is both pending and unmasked.
- R7: `irqVec` gives the lowest-numbered active arbitration line, and is 0 when no line is active. `periphVec` gives the lowest-numbered pending, unmasked peripheral, and is 0 when there is none. This makes line 0 and PWM trip the highest priorities.
- R8: `irqReq` is 1 only when `globalEn` is 1 and at least one line is active. Edges are still captured while `globalEn` is 0.
- R9: When `ack` is 1, `irqReq` is 1 and `irqVec` is k ≥ 1, core pending bit k-1 clears at the next edge unless a new edge on that source arrives in the same cycle. `ack` has no effect when `irqVec` is 0 or `irqReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreReq | input | 5 | Core-level request inputs |
| coreMask | input | 5 | Core enable mask, 1 = enabled |
| periphReq | input | 11 | Peripheral request inputs |
| periphMask | input | 11 | Peripheral enable mask, 1 = enabled |
| periphClrWr | input | 1 | Strobe for the write-one-to-clear of peripheral status |
| periphClrData | input | 11 | Bits to clear in peripheral status |
| globalEn | input | 1 | Global interrupt enable |
| ack | input | 1 | Acknowledge of the current vector |
| irqReq | output | 1 | Interrupt request to the core |
| irqVec | output | 3 | Index of the winning arbitration line |
| periphStatus | output | 11 | Peripheral pending bits |
| periphVec | output | 4 | Index of the highest-priority active peripheral |

## Verification
The bench builds the block with the package defaults of five core sources and eleven peripheral sources. All six arbitration lines and all eleven status bits are therefore exercised, including the ranking of PWM trip above the I/O lines. At these sizes random toggling of requests, masks, clears and acknowledges often lands an edge on the same cycle as a clear or an acknowledge. Directed steps force those same-cycle cases, plus the masked-but-pending state and the case where the global enable is off.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int CORE_SRC   = 5;
  localparam int PERIPH_SRC = 11;
  localparam int LINES      = CORE_SRC + 1;
  localparam int VEC_W      = $clog2(LINES);
  localparam int PVEC_W     = $clog2(PERIPH_SRC);

  // strobes from control to datapath
  typedef struct packed {
    logic [CORE_SRC-1:0] coreClr;
  } ctlStrobe_t;
endpackage

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CORE_SRC-1:0]   coreReq,
  input  logic [CORE_SRC-1:0]   coreMask,
  input  logic [PERIPH_SRC-1:0] periphReq,
  input  logic [PERIPH_SRC-1:0] periphMask,
  input  logic                  periphClrWr,
  input  logic [PERIPH_SRC-1:0] periphClrData,
  input  ctlStrobe_t            strobe,
  output logic [LINES-1:0]      lineReq,
  output logic [PERIPH_SRC-1:0] periphPend,
  output logic [PERIPH_SRC-1:0] periphActive
);
  logic [CORE_SRC-1:0]   prevCore, corePend, coreRise;
  logic [PERIPH_SRC-1:0] prevPer, perRise, perClr;

  assign coreRise = coreReq & ~prevCore;
  assign perRise  = periphReq & ~prevPer;
  assign perClr   = periphClrWr ? periphClrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCore   <= '0;
      prevPer    <= '0;
      corePend   <= '0;
      periphPend <= '0;
    end else begin
      prevCore   <= coreReq;
      prevPer    <= periphReq;
      corePend   <= (corePend & ~strobe.coreClr) | coreRise;
      periphPend <= (periphPend & ~perClr) | perRise;
    end
  end

  assign periphActive = periphPend & periphMask;
  assign lineReq      = {corePend & coreMask, |periphActive};

  genvar gi;
  generate
    for (gi = 0; gi < CORE_SRC; gi++) begin : gCoreChk
      assert_core_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
        (coreReq[gi] && !prevCore[gi]) |=> corePend[gi]);
      assert_core_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        (corePend[gi] && !strobe.coreClr[gi]) |=> corePend[gi]);
    end
    for (gi = 0; gi < PERIPH_SRC; gi++) begin : gPerChk
      assert_per_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
        (periphReq[gi] && !prevPer[gi]) |=> periphPend[gi]);
      assert_per_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
        (periphClrWr && periphClrData[gi] && !(periphReq[gi] && !prevPer[gi])) |=> !periphPend[gi]);
      assert_per_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
        (periphPend[gi] && !(periphClrWr && periphClrData[gi])) |=> periphPend[gi]);
    end
  endgenerate
endmodule

// File: rtl/irqControl.sv
module irqControl
  import irqPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  globalEn,
  input  logic                  ack,
  input  logic [LINES-1:0]      lineReq,
  input  logic [PERIPH_SRC-1:0] periphActive,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      irqVec,
  output logic [PVEC_W-1:0]     periphVec,
  output ctlStrobe_t            strobe
);
  // lowest set index wins
  always_comb begin
    irqVec = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (lineReq[i]) irqVec = VEC_W'(i);
  end

  always_comb begin
    periphVec = '0;
    for (int i = PERIPH_SRC - 1; i >= 0; i--)
      if (periphActive[i]) periphVec = PVEC_W'(i);
  end

  assign irqReq = globalEn & (|lineReq);

  genvar gi;
  generate
    for (gi = 0; gi < CORE_SRC; gi++) begin : gClr
      assign strobe.coreClr[gi] = ack & irqReq & (irqVec == VEC_W'(gi + 1));
    end
  endgenerate

  assert_winner_active_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> lineReq[irqVec]);
  assert_no_higher_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((lineReq & ((LINES'(1) << irqVec) - LINES'(1))) == '0));
  assert_periph_winner_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|periphActive) |-> periphActive[periphVec]);
  assert_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irqReq);
  assert_clr_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.coreClr));
  assert_clr_needs_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.coreClr) |-> (ack && irqReq));
endmodule

// File: rtl/irqController.sv
module irqController
  import irqPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CORE_SRC-1:0]   coreReq,
  input  logic [CORE_SRC-1:0]   coreMask,
  input  logic [PERIPH_SRC-1:0] periphReq,
  input  logic [PERIPH_SRC-1:0] periphMask,
  input  logic                  periphClrWr,
  input  logic [PERIPH_SRC-1:0] periphClrData,
  input  logic                  globalEn,
  input  logic                  ack,
  output logic                  irqReq,
  output logic [VEC_W-1:0]      irqVec,
  output logic [PERIPH_SRC-1:0] periphStatus,
  output logic [PVEC_W-1:0]     periphVec
);
  ctlStrobe_t              strobe;
  logic [LINES-1:0]        lineReq;
  logic [PERIPH_SRC-1:0]   periphActive;

  irqDatapath uDp (
    .clk(clk), .rstN(rstN),
    .coreReq(coreReq), .coreMask(coreMask),
    .periphReq(periphReq), .periphMask(periphMask),
    .periphClrWr(periphClrWr), .periphClrData(periphClrData),
    .strobe(strobe), .lineReq(lineReq),
    .periphPend(periphStatus), .periphActive(periphActive)
  );

  irqControl uCtl (
    .clk(clk), .rstN(rstN),
    .globalEn(globalEn), .ack(ack),
    .lineReq(lineReq), .periphActive(periphActive),
    .irqReq(irqReq), .irqVec(irqVec), .periphVec(periphVec),
    .strobe(strobe)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (periphStatus == '0));
endmodule

// File: tb/sim_irqController.sv
`timescale 1ns/100ps
module sim_irqController;
  import irqPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CORE_SRC-1:0]   coreReq = '0, coreMask = '0;
  logic [PERIPH_SRC-1:0] periphReq = '0, periphMask = '0, periphClrData = '0;
  logic periphClrWr = 1'b0, globalEn = 1'b0, ack = 1'b0;
  logic irqReq;
  logic [VEC_W-1:0]      irqVec;
  logic [PERIPH_SRC-1:0] periphStatus;
  logic [PVEC_W-1:0]     periphVec;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [CORE_SRC-1:0]   mPrevC = '0, mPendC = '0;
  logic [PERIPH_SRC-1:0] mPrevP = '0, mPendP = '0;

  always #2.5 clk = ~clk;

  irqController u0 (
    .clk(clk), .rstN(rstN), .coreReq(coreReq), .coreMask(coreMask),
    .periphReq(periphReq), .periphMask(periphMask),
    .periphClrWr(periphClrWr), .periphClrData(periphClrData),
    .globalEn(globalEn), .ack(ack), .irqReq(irqReq), .irqVec(irqVec),
    .periphStatus(periphStatus), .periphVec(periphVec)
  );

  function automatic logic [LINES-1:0] expLines();
    return {mPendC & coreMask, |(mPendP & periphMask)};
  endfunction

  function automatic int lowIdx(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic expReq();
    return globalEn && (|expLines());
  endfunction

  task automatic checkVal(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    checkVal(tag, "irqReq", int'(irqReq), int'(expReq()));
    checkVal(tag, "irqVec", int'(irqVec), lowIdx(32'(expLines()), LINES));
    checkVal(tag, "periphStatus", int'(periphStatus), int'(mPendP));
    checkVal(tag, "periphVec", int'(periphVec), lowIdx(32'(mPendP & periphMask), PERIPH_SRC));
  endtask

  // one clock with current inputs; model updated, then sampled at negedge
  task automatic step(input string tag);
    logic [CORE_SRC-1:0]   clrC;
    logic [PERIPH_SRC-1:0] clrP;
    int v;
    v = lowIdx(32'(expLines()), LINES);
    for (int i = 0; i < CORE_SRC; i++) clrC[i] = ack && expReq() && (v == i + 1);
    clrP = periphClrWr ? periphClrData : '0;
    @(posedge clk);
    mPendC = (mPendC & ~clrC) | (coreReq & ~mPrevC);
    mPendP = (mPendP & ~clrP) | (periphReq & ~mPrevP);
    mPrevC = coreReq;
    mPrevP = periphReq;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, with inputs toggling during reset
    coreReq = '1; periphReq = '1; coreMask = '1; periphMask = '1; globalEn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R1");
    coreReq = '0; periphReq = '0;
    @(negedge clk);
    rstN = 1'b1;
    step("R1");

    // R3: capture, level held does not retrigger after clear
    periphReq[4] = 1'b1; step("R3");
    periphReq[4] = 1'b1; step("R3");
    periphClrWr = 1'b1; periphClrData = 11'h010; step("R4");
    periphClrWr = 1'b0; periphClrData = '0;
    repeat (3) step("R3 no retrigger");

    // R4: clear and new edge in same cycle -> stays set
    periphReq[5] = 1'b1; step("R4");
    periphReq[5] = 1'b0; step("R4");
    periphReq[5] = 1'b1; periphClrWr = 1'b1; periphClrData = 11'h020; step("R4 race");
    periphClrWr = 1'b0; periphClrData = '0;

    // R5, R6: masked peripheral keeps status but no request
    periphMask = '0; step("R5");
    periphMask = 11'h020; step("R6");
    // R7: PWM trip outranks I/O lines
    periphReq[0] = 1'b1; periphMask = '1; step("R7 trip first");
    // R7: core and aggregate both active -> line 0 wins
    coreReq[2] = 1'b1; step("R7 line0");
    // R9: ack while vector is 0 has no effect
    ack = 1'b1; step("R9 ack line0");
    ack = 1'b0;
    periphClrWr = 1'b1; periphClrData = '1; step("R4 clear all");
    periphClrWr = 1'b0; periphClrData = '0;
    step("R7 timer line");
    // R8: global enable off
    globalEn = 1'b0; coreReq[0] = 1'b1; step("R8");
    ack = 1'b1; step("R8 R9 ack ignored");
    ack = 1'b0; globalEn = 1'b1; step("R8");
    // R9: ack clears serviced core source
    ack = 1'b1; step("R9 ack");
    ack = 1'b0; step("R9");
    // R5: masked core source stays pending
    coreMask = 5'b11011; step("R5 core mask");
    coreMask = '1; step("R5 core unmask");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < CORE_SRC; i++)
        if ($urandom_range(0, 5) == 0) coreReq[i] = ~coreReq[i];
      for (int i = 0; i < PERIPH_SRC; i++)
        if ($urandom_range(0, 7) == 0) periphReq[i] = ~periphReq[i];
      if ($urandom_range(0, 15) == 0) coreMask = CORE_SRC'($urandom);
      if ($urandom_range(0, 15) == 0) periphMask = PERIPH_SRC'($urandom);
      periphClrWr = ($urandom_range(0, 3) == 0);
      periphClrData = PERIPH_SRC'($urandom);
      ack = ($urandom_range(0, 2) == 0);
      globalEn = ($urandom_range(0, 9) != 0);
      step("R2 R3 R5 R6 R7 R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule